// File: doc/BRIEF.md
# Cascaded Watchdog Timer

This block is a two-stage watchdog built from a short low-order down-counter and a longer high-order down-counter. A free-running prescaler divides the system clock by 256 and paces the low counter. The high counter is clocked either by the low counter's underflow or directly by the prescaler tick, so the timeout is one of two lengths. When the high counter underflows, the block issues a one-clock non-maskable interrupt request. The counters then wrap and keep running.

Software controls the block through a single 8-bit register on a synchronous bus. Any write to that register reloads both counters to all ones and arms the watchdog, whatever the data is. A write also latches the source selection and can set a stop-disable flag. That flag cannot be cleared again, and it drives an output for the core's instruction logic. Once armed, the watchdog keeps counting until reset. Reads return the register contents and leave the counters untouched.

Top module: `wdog_cascade`

## Requirements
- R1: Reset state. After reset `bus_rdata` is 0x00, `nmi_req` is 0 and `stop_dis` is 0. The counters stay idle, and no interrupt can occur until the first selected write.
- R2: Reload. A write is `bus_sel` and `bus_we` both high. It loads the high counter with 0x7F and the low counter with 0xF and arms the watchdog. The data value has no effect on the reload, so regular writes of any data prevent a timeout.
- R3: Prescaler mode. With bit 7 of the written data at 1, the high counter steps once per prescaler tick (every 2^PRE_W clocks). The timeout is 128 ticks (32768 clocks at the defaults). Because the prescaler phase varies, the interrupt appears between 127·2^PRE_W+1 and 128·2^PRE_W clocks after the write edge.
- R4: Cascaded mode. With bit 7 at 0, the high counter steps on each low-counter underflow. The low counter underflows every 16 ticks, so the timeout is 2048 ticks (524288 clocks at the defaults), with the same phase window as R3.
- R5: `nmi_req` is a registered pulse exactly one clock wide. It rises in the cycle after the high counter underflows.
- R6: After an underflow, both counters wrap to all ones and keep counting. Without another write, the next interrupt follows exactly one full period later (128·2^PRE_W clocks in prescaler mode).
- R7: Once armed, the watchdog cannot be stopped by any write data. Only reset returns it to idle.
- R8: Bit 6 of the register is the stop-disable flag, and `stop_dis` shows it. Writing 1 sets it. Writes of 0 leave it at 1 until reset.
- R9: A selected read (`bus_sel` and `bus_re`) updates `bus_rdata` one clock later:
  - bits 5..0 read as 1;
  - bit 6 reads the stop-disable flag;
  - bit 7 reads the source selection;
  - a read in the same cycle as a write returns the value from before that write;
  - `bus_rdata` holds between reads.
- R10: Reads do not change the counters or the timeout.
- R11: The prescaler runs freely from reset. Writes do not reset it.
- R12: With `bus_sel` low, write and read strobes are ignored. They do not reload the counters and do not change `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Address match for the watchdog register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data (bit 7 source select, bit 6 stop-disable) |
| bus_rdata | output | DW | Registered read data |
| nmi_req | output | 1 | One-clock non-maskable interrupt request |
| stop_dis | output | 1 | Sticky stop-instruction disable flag |

## Verification
The bench overrides the prescaler width to 4 so that both timeout lengths fit in the run. It measures the clocks from a write to the interrupt and checks them against the phase window. A design that reset the prescaler on writes, or counted one step too many or too few, would land outside that window or disagree with the per-clock model.

The bench also checks these cases:
- Without a write, the second interrupt must follow the first by exactly one period. A block that stopped or failed to wrap would never raise it.
- Reads during that period must not shift it.
- Writing 0 must leave the stop-disable flag set.
- Strobes with `bus_sel` low must neither delay the timeout nor change the read data.
- Kicks with varied data must keep the interrupt silent. A block that decoded the data for the reload would let the interrupt through.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Clock source of the high-order counter
  typedef enum logic {
    SRC_CASCADE  = 1'b0,
    SRC_PRESCALE = 1'b1
  } hi_src_e;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  logic [PRE_W-1:0] div_q;

  // Free-running divider; never reloaded by the bus
  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign tick = &div_q;

  AST_PRE_WRAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (div_q == '0)); // R11

endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         uf
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= TOP;
    else if (load) cnt <= TOP;
    else if (en)   cnt <= cnt - 1'b1;
  end

  // Underflow: a step taken from zero; a reload in the same cycle wins
  assign uf = en & ~load & (cnt == '0);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(cnt)); // R10
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    uf |=> (cnt == TOP)); // R6

endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
#(
  parameter int DW      = 8,
  parameter int SEL_BIT = 7,
  parameter int STP_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output hi_src_e       src,
  output logic          stop_dis,
  output logic          running
);

  logic [DW-1:0] rd_word;

  // Read image: selection and flag at their positions, other bits one
  for (genvar i = 0; i < DW; i++) begin : g_rd_bit
    if (i == SEL_BIT) begin : g_sel
      assign rd_word[i] = src;
    end else if (i == STP_BIT) begin : g_stp
      assign rd_word[i] = stop_dis;
    end else begin : g_pad
      assign rd_word[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      src      <= SRC_CASCADE;
      stop_dis <= 1'b0;
      rdata    <= '0;
    end else begin
      if (wr) begin
        running <= 1'b1;
        src     <= hi_src_e'(wdata[SEL_BIT]);
        if (wdata[STP_BIT]) stop_dis <= 1'b1;
      end
      if (rd) rdata <= rd_word;
    end
  end

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    running |=> running); // R7
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
    stop_dis |=> stop_dis); // R8
  AST_RD_SEL: assert property (@(posedge clk) disable iff (rst)
    rd |=> (rdata[SEL_BIT] == $past(src))); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata)); // R9

endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade
  import wdog_pkg::*;
#(
  parameter int PRE_W   = 8,
  parameter int LO_W    = 4,
  parameter int HI_W    = 7,
  parameter int DW      = 8,
  parameter int SEL_BIT = 7,
  parameter int STP_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          nmi_req,
  output logic          stop_dis
);

  logic            wr, rd, tick, running;
  logic            lo_en, lo_uf, hi_en, hi_uf;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;
  hi_src_e         src;

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & bus_re;

  wdog_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  wdog_ctrl_reg #(.DW(DW), .SEL_BIT(SEL_BIT), .STP_BIT(STP_BIT)) i_reg (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr),
    .rd      (rd),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .src     (src),
    .stop_dis(stop_dis),
    .running (running)
  );

  assign lo_en = running & tick;
  assign hi_en = running & ((src == SRC_PRESCALE) ? tick : lo_uf);

  wdog_downcnt #(.W(LO_W)) i_lo (
    .clk (clk),
    .rst (rst),
    .load(wr),
    .en  (lo_en),
    .cnt (lo_cnt),
    .uf  (lo_uf)
  );

  wdog_downcnt #(.W(HI_W)) i_hi (
    .clk (clk),
    .rst (rst),
    .load(wr),
    .en  (hi_en),
    .cnt (hi_cnt),
    .uf  (hi_uf)
  );

  always_ff @(posedge clk) begin
    if (rst) nmi_req <= 1'b0;
    else     nmi_req <= hi_uf;
  end

  AST_NMI_PULSE: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> !nmi_req); // R5
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    wr |=> (lo_cnt == '1 && hi_cnt == '1)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !running |=> !nmi_req); // R1

endmodule

// File: tb/test_wdog_cascade.sv
module test_wdog_cascade;

  localparam int P      = 4;
  localparam int TICK   = 1 << P;
  localparam int PERIOD = 128 * TICK;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_i = 1'b1, we_i = 1'b0, re_i = 1'b0;
  logic [7:0] wd_i = 8'h00;
  logic [7:0] rdata;
  logic       nmi, stp;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // Reference model state
  int m_pre, m_lo, m_hi, m_run, m_src, m_stp, m_nmi, m_rd;

  always #5 clk = ~clk;

  wdog_cascade #(.PRE_W(P)) i_wdog_cascade (
    .clk(clk), .rst(rst), .bus_sel(sel_i), .bus_we(we_i), .bus_re(re_i),
    .bus_wdata(wd_i), .bus_rdata(rdata), .nmi_req(nmi), .stop_dis(stp)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // Behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_pre = 0; m_lo = 15; m_hi = 127; m_run = 0;
      m_src = 0; m_stp = 0; m_nmi = 0; m_rd = 0;
    end else begin
      bit w, r, tk, lou, hie;
      w   = sel_i && we_i;
      r   = sel_i && re_i;
      tk  = (m_pre == TICK - 1);
      lou = m_run && tk && m_lo == 0 && !w;
      hie = m_run && (m_src ? tk : lou);
      m_nmi = (hie && m_hi == 0 && !w);
      if (r) m_rd = (m_src << 7) | (m_stp << 6) | 8'h3F;
      if (w) begin
        m_lo = 15; m_hi = 127; m_run = 1; m_src = wd_i[7];
        if (wd_i[6]) m_stp = 1;
      end else if (m_run) begin
        if (tk)  m_lo = (m_lo + 15) % 16;
        if (hie) m_hi = (m_hi + 127) % 128;
      end
      m_pre = (m_pre + 1) % TICK;
    end
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  // Per-clock comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      check(rdata == m_rd[7:0], "R9 rdata vs model", rdata, m_rd);
      check(nmi == m_nmi[0], "R5/R11 nmi vs model", nmi, m_nmi);
      check(stp == m_stp[0], "R8 stop_dis vs model", stp, m_stp);
    end
  end

  task automatic bus_write(input logic [7:0] d);
    sel_i = 1'b1; we_i = 1'b1; wd_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic bus_read(output logic [7:0] v);
    sel_i = 1'b1; re_i = 1'b1;
    @(negedge clk);
    re_i = 1'b0;
    v = rdata;
  endtask

  task automatic wait_nmi(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!nmi && n < 40000);
  endtask

  initial begin
    logic [7:0] v;
    int n, seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    check(rdata == 8'h00, "R1 rdata after reset", rdata, 0);
    check(nmi == 1'b0, "R1 nmi after reset", nmi, 0);
    check(stp == 1'b0, "R1 stop_dis after reset", stp, 0);
    // R1: idle without a write
    seen = 0;
    repeat (3 * PERIOD) begin @(negedge clk); if (nmi) seen++; end
    check(seen == 0, "R1 idle before first write", seen, 0);
    // R9: pad bits read as one
    bus_read(v);
    check(v == 8'h3F, "R9 read after reset", v, 8'h3F);
    // R3: prescaler-mode timeout window
    bus_write(8'h80);
    wait_nmi(n);
    check(n >= PERIOD - TICK + 1 && n <= PERIOD, "R3 timeout window", n, PERIOD);
    @(negedge clk);
    check(nmi == 1'b0, "R5 pulse width one clock", nmi, 0);
    // R6 and R10: next timeout one period later, with reads in between
    n = 1;
    do begin
      re_i = (n % 50 == 0);
      @(negedge clk); n++;
    end while (!nmi && n < 40000);
    re_i = 1'b0;
    check(n == PERIOD, "R6 R10 wrap period with reads", n, PERIOD);
    bus_read(v);
    check(v == 8'hBF, "R9 read with prescaler source", v, 8'hBF);
    // R2: kicks with varied data keep the interrupt silent
    seen = 0;
    foreach (wd_pat[k]) begin
      bus_write(wd_pat[k]);
      repeat (PERIOD - 300) begin @(negedge clk); if (nmi) seen++; end
    end
    check(seen == 0, "R2 kicks prevent timeout", seen, 0);
    // R12: strobes with bus_sel low are ignored
    bus_write(8'h80);
    bus_read(v);
    repeat (400) @(negedge clk);
    sel_i = 1'b0; we_i = 1'b1; re_i = 1'b1; wd_i = 8'h00;
    @(negedge clk);
    we_i = 1'b0; re_i = 1'b0; sel_i = 1'b1;
    check(rdata == v, "R12 unselected read ignored", rdata, v);
    wait_nmi(n);
    n = n + 402;
    check(n >= PERIOD - TICK + 1 && n <= PERIOD, "R12 unselected write ignored", n, PERIOD);
    // R8: sticky stop-disable flag
    bus_write(8'hC0);
    bus_read(v);
    check(v == 8'hFF && stp, "R8 flag set", v, 8'hFF);
    bus_write(8'h80);
    bus_read(v);
    check(v == 8'hFF, "R8 write 0 ignored", v, 8'hFF);
    // R4 and R7: cascaded mode, still running after a write of zero
    bus_write(8'h00);
    wait_nmi(n);
    check(n >= 16 * PERIOD - TICK + 1 && n <= 16 * PERIOD, "R4 R7 cascaded timeout", n, 16 * PERIOD);
    bus_read(v);
    check(v == 8'h7F && stp, "R8 R9 flag kept, cascade source", v, 8'h7F);
    repeat (5) @(negedge clk);
    finish_up();
  end

  logic [7:0] wd_pat [4] = '{8'h80, 8'h9A, 8'hA5, 8'h85};

endmodule